// File: doc/BRIEF.md
# Serial adapter host register interface

This block is the processor-facing register file of an asynchronous serial adapter. It sits between a simple byte-wide bus and separate transmitter and receiver engines. One register-select line and two strobes give the processor two addresses. Each address is write-only in one direction and read-only in the other.

The block stores the control word and decodes it into a clock-divide selection and a word-format description for the serial engines. It holds one byte waiting for the transmitter and one received byte. From the receiver's error flags, the modem inputs and its own flags it assembles the status byte. It drives an active-low interrupt line.

There is no reset pin. The device starts in a held-reset state and leaves it only through a control write. Flags are cleared by the side effects of register accesses.

Top module: `serial_host_regs`

## Requirements
- R1: With `reg_sel`=0, a write loads the transmit byte (seen on `tx_data`) and a read returns the status byte. With `reg_sel`=1, a write loads the control word and a read returns the last received byte.
- R2: From power-up until the first control write whose bits 1:0 are not 11, the following hold. `in_reset`=1 and `irq_n`=1. `tx_valid`=0 and transmit-byte writes are ignored. Received characters are ignored. Status reads as zero except bit 3 (`cts_n`) and bit 2 (`dcd_n`).
- R3: A control write with bits 1:0 = 11 enters reset. It clears the received byte, the transmit byte and every flag, including any character arriving in the same cycle. A later control write with bits 1:0 other than 11 leaves reset, and TDRE (status bit 1) then reads 1.
- R4: `div_sel` equals control bits 1:0 (00 = divide by 1, 01 = divide by 16, 10 = divide by 64, 11 = reset).
- R5: Control bits 4:2 decode to the word format {data bits, parity, stop bits} as follows: 000=7E2, 001=7O2, 010=7E1, 011=7O1, 100=8N2, 101=8N1, 110=8E1, 111=8O1. The outputs are `fmt_8bit`, `fmt_par_en`, `fmt_par_odd` and `fmt_2stop`.
- R6: An arriving character (`rx_valid`) stores `rx_byte` and sets RDRF (status bit 0). Reading the received byte clears RDRF, and the byte stays readable. When an arrival and a read fall in the same cycle, the arrival wins.
- R7: OVRN (status bit 5) is the overrun flag. An arrival while RDRF=1, with no read in the same cycle, sets OVRN and overwrites the stored byte. An arrival while RDRF=0 clears OVRN, and a read of the received byte also clears it.
- R8: PE (status bit 6) and FE (status bit 4) take the values of `rx_par_err` and `rx_frm_err` at each arrival. A read of the received byte clears both.
- R9: TDRE is 0 while a transmit byte is pending. A transmit write makes a byte pending. `tx_valid` is high when a byte is pending and `cts_n`=0. While `tx_valid` is high, `tx_take` ends the pending state.
- R10: While `cts_n`=1, `tx_valid` stays 0 and `tx_take` has no effect, so TDRE stays 0.
- R11: IRQ (status bit 7) is 1 outside reset when either (control bit 7 and (RDRF or OVRN)) or (control bits 6:5 = 01 and TDRE) holds. `irq_n` is the inverse of IRQ.
- R12: Status bits 3 and 2 follow the `cts_n` and `dcd_n` inputs directly, in and out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| reg_sel | input | 1 | Register select |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the current `reg_sel` |
| tx_data | output | 8 | Byte held for the transmitter |
| tx_valid | output | 1 | Byte pending and clear to send |
| tx_take | input | 1 | Transmitter has taken the byte |
| rx_valid | input | 1 | Receiver delivers a character |
| rx_byte | input | 8 | Received character |
| rx_par_err | input | 1 | Parity error of this character |
| rx_frm_err | input | 1 | Missing stop bit of this character |
| cts_n | input | 1 | Clear to send, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| in_reset | output | 1 | Block held in reset |
| div_sel | output | 2 | Clock divide code |
| fmt_8bit | output | 1 | Eight data bits (else seven) |
| fmt_par_en | output | 1 | Parity bit present |
| fmt_par_odd | output | 1 | Parity is odd |
| fmt_2stop | output | 1 | Two stop bits |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The hardest situations to reach are the ones where several access side effects fall in one cycle. Examples are a received-byte read together with an arrival while RDRF is set, and a master reset that coincides with an incoming character. Random stimulus places arrivals, reads, takes and writes independently in every cycle, so these collisions occur often. Directed steps also force each one once. A bench model follows the stated priority rules and compares every output, and both readable registers, after each cycle.

// File: rtl/serial_host_regs.sv
module serial_host_regs (
  input  logic       clk,
  input  logic       reg_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  input  logic       tx_take,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       rx_par_err,
  input  logic       rx_frm_err,
  input  logic       cts_n,
  input  logic       dcd_n,
  output logic       in_reset,
  output logic [1:0] div_sel,
  output logic       fmt_8bit,
  output logic       fmt_par_en,
  output logic       fmt_par_odd,
  output logic       fmt_2stop,
  output logic       irq_n
);

  logic       in_rst = 1'b1;
  logic [7:0] ctrl   = 8'h03;
  logic [7:0] tx_q   = 8'h00;
  logic       pend   = 1'b0;
  logic [7:0] rx_q   = 8'h00;
  logic       rdrf   = 1'b0;
  logic       ovrn   = 1'b0;
  logic       pe     = 1'b0;
  logic       fe     = 1'b0;

  logic ctl_wr, tx_wr, rx_rd, mreset, take_ok, tdre, irq;

  assign ctl_wr  = wr_en & reg_sel;
  assign tx_wr   = wr_en & ~reg_sel & ~in_rst;
  assign rx_rd   = rd_en & reg_sel;
  assign mreset  = ctl_wr & (wr_data[1:0] == 2'b11);
  assign take_ok = tx_valid & tx_take;
  assign tdre    = ~in_rst & ~pend;

  always_ff @(posedge clk) begin
    if (ctl_wr) begin
      ctrl   <= wr_data;
      in_rst <= mreset;
    end
  end

  always_ff @(posedge clk) begin
    if (mreset) begin
      tx_q <= 8'h00;
      pend <= 1'b0;
    end else if (tx_wr) begin
      tx_q <= wr_data;
      pend <= 1'b1;
    end else if (take_ok) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (mreset) begin
      rx_q <= 8'h00;
      rdrf <= 1'b0;
      ovrn <= 1'b0;
      pe   <= 1'b0;
      fe   <= 1'b0;
    end else if (!in_rst) begin
      if (rx_valid) begin
        rx_q <= rx_byte;
        ovrn <= rdrf & ~rx_rd;
        rdrf <= 1'b1;
        pe   <= rx_par_err;
        fe   <= rx_frm_err;
      end else if (rx_rd) begin
        rdrf <= 1'b0;
        ovrn <= 1'b0;
        pe   <= 1'b0;
        fe   <= 1'b0;
      end
    end
  end

  assign irq = ~in_rst & ((ctrl[7] & (rdrf | ovrn)) | ((ctrl[6:5] == 2'b01) & tdre));

  assign rd_data  = reg_sel ? rx_q : {irq, pe, ovrn, fe, cts_n, dcd_n, tdre, rdrf};
  assign tx_data  = tx_q;
  assign tx_valid = pend & ~cts_n & ~in_rst;
  assign in_reset = in_rst;
  assign irq_n    = ~irq;
  assign div_sel  = ctrl[1:0];

  assign fmt_8bit    = ctrl[4];
  assign fmt_par_en  = ~ctrl[4] | ctrl[3];
  assign fmt_par_odd = (~ctrl[4] | ctrl[3]) & ctrl[2];
  assign fmt_2stop   = ~ctrl[3] & (~ctrl[4] | ~ctrl[2]);

endmodule

module serial_host_regs_chk (
  input logic       clk,
  input logic       reg_sel,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wr_data,
  input logic       rx_valid,
  input logic       cts_n,
  input logic       in_rst,
  input logic [7:0] ctrl,
  input logic       pend,
  input logic       rdrf,
  input logic       ovrn,
  input logic       tx_valid,
  input logic       irq_n
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!started)
    (rd_en && reg_sel && !rx_valid && !in_rst) |=> !rdrf); // R6
  AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!started)
    (rx_valid && rdrf && !(rd_en && reg_sel) && !in_rst && !(wr_en && reg_sel && wr_data[1:0] == 2'b11)) |=> ovrn); // R7
  AST_TX_WRITE_PENDS: assert property (@(posedge clk) disable iff (!started)
    (wr_en && !reg_sel && !in_rst) |=> pend); // R9
  AST_CTS_BLOCKS: assert property (@(posedge clk) disable iff (!started)
    cts_n |-> !tx_valid); // R10
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!started)
    in_rst |-> (irq_n && !tx_valid && !rdrf && !pend)); // R2
  AST_MASTER_RESET: assert property (@(posedge clk) disable iff (!started)
    (wr_en && reg_sel && wr_data[1:0] == 2'b11) |=> (in_rst && !ovrn && !rdrf)); // R3
  AST_RX_IRQ: assert property (@(posedge clk) disable iff (!started)
    (!in_rst && ctrl[7] && rdrf) |-> !irq_n); // R11
endmodule

bind serial_host_regs serial_host_regs_chk u_chk (.*);

// File: tb/sim_serial_host_regs.sv
module sim_serial_host_regs;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic reg_sel = 0, wr_en = 0, rd_en = 0, tx_take = 0, rx_valid = 0;
  logic rx_par_err = 0, rx_frm_err = 0, cts_n = 0, dcd_n = 0;
  logic [7:0] wr_data = 0, rx_byte = 0;
  logic [7:0] rd_data, tx_data;
  logic tx_valid, in_reset, fmt_8bit, fmt_par_en, fmt_par_odd, fmt_2stop, irq_n;
  logic [1:0] div_sel;

  serial_host_regs u0 (.*);

  int checks = 0, fails = 0;
  logic       m_rst = 1, m_pend = 0, m_rdrf = 0, m_ovrn = 0, m_pe = 0, m_fe = 0;
  logic [7:0] m_ctrl = 8'h03, m_tx = 0, m_rx = 0;

  function automatic logic m_irq();
    return !m_rst && ((m_ctrl[7] && (m_rdrf || m_ovrn)) || (m_ctrl[6:5] == 2'b01 && !m_pend));
  endfunction
  function automatic logic [7:0] m_status();
    return {m_irq(), m_pe, m_ovrn, m_fe, cts_n, dcd_n, !m_rst && !m_pend, m_rdrf};
  endfunction
  function automatic logic [3:0] m_fmt(input logic [2:0] c);
    case (c)
      3'd0: return 4'b0101; 3'd1: return 4'b0111; 3'd2: return 4'b0100; 3'd3: return 4'b0110;
      3'd4: return 4'b1001; 3'd5: return 4'b1000; 3'd6: return 4'b1100; default: return 4'b1110;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic sel, input logic wr, input logic rd,
                      input logic [7:0] wd, input logic rxv, input logic [7:0] rb,
                      input logic p, input logic f, input logic tk);
    logic old_rst, rdread;
    @(negedge clk);
    reg_sel = sel; wr_en = wr; rd_en = rd; wr_data = wd;
    rx_valid = rxv; rx_byte = rb; rx_par_err = p; rx_frm_err = f; tx_take = tk;
    old_rst = m_rst;
    rdread = rd && sel;
    if (wr && sel) begin
      m_ctrl = wd;
      m_rst = (wd[1:0] == 2'b11);
    end
    if (wr && sel && wd[1:0] == 2'b11) begin
      m_tx = 0; m_pend = 0; m_rx = 0; m_rdrf = 0; m_ovrn = 0; m_pe = 0; m_fe = 0;
    end else if (!old_rst) begin
      if (wr && !sel) begin m_tx = wd; m_pend = 1; end
      else if (tk && m_pend && !cts_n) m_pend = 0;
      if (rxv) begin
        m_ovrn = m_rdrf && !rdread; m_rdrf = 1; m_rx = rb; m_pe = p; m_fe = f;
      end else if (rdread) begin
        m_rdrf = 0; m_ovrn = 0; m_pe = 0; m_fe = 0;
      end
    end
    @(posedge clk);
    #1;
    wr_en = 0; rd_en = 0; rx_valid = 0; tx_take = 0; reg_sel = 0;
    #1;
    chk(tag, "status", rd_data, m_status());
    chk(tag, "irq_n", {7'd0, irq_n}, {7'd0, !m_irq()});
    chk(tag, "tx_valid", {7'd0, tx_valid}, {7'd0, m_pend && !cts_n && !m_rst});
    chk(tag, "tx_data", tx_data, m_tx);
    chk(tag, "in_reset", {7'd0, in_reset}, {7'd0, m_rst});
    chk(tag, "div_sel", {6'd0, div_sel}, {6'd0, m_ctrl[1:0]});
    chk(tag, "fmt", {4'd0, fmt_8bit, fmt_par_en, fmt_par_odd, fmt_2stop}, {4'd0, m_fmt(m_ctrl[4:2])});
    reg_sel = 1;
    #1;
    chk(tag, "rx_data", rd_data, m_rx);
    reg_sel = 0;
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);
  endtask

  initial begin
    #1;
    chk("R2", "status at power-up", rd_data, 8'h00);
    chk("R2", "irq_n at power-up", {7'd0, irq_n}, 8'h01);
    idle("R2");
    step("R2", 0, 1, 0, 8'hA5, 1, 8'h3C, 1, 1, 0);
    step("R2", 0, 0, 1, 8'h00, 0, 8'h00, 0, 0, 1);
    step("R3", 1, 1, 0, 8'h03, 0, 8'h00, 0, 0, 0);
    step("R3", 1, 1, 0, 8'h95, 0, 8'h00, 0, 0, 0);
    for (int c = 0; c < 8; c++) step("R5", 1, 1, 0, {3'b000, c[2:0], 2'(c % 3)}, 0, 0, 0, 0, 0);
    step("R4", 1, 1, 0, 8'h02, 0, 8'h00, 0, 0, 0);
    step("R4", 1, 1, 0, 8'h21, 0, 8'h00, 0, 0, 0);
    step("R11", 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);
    step("R1", 0, 1, 0, 8'h5A, 0, 8'h00, 0, 0, 0);
    step("R9", 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 1);
    cts_n = 1;
    step("R10", 0, 1, 0, 8'hC3, 0, 8'h00, 0, 0, 0);
    step("R10", 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 1);
    dcd_n = 1;
    idle("R12");
    cts_n = 0;
    step("R9", 0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 1);
    step("R1", 1, 1, 0, 8'h81, 0, 8'h00, 0, 0, 0);
    step("R6", 0, 0, 0, 8'h00, 1, 8'h11, 0, 0, 0);
    step("R6", 0, 0, 1, 8'h00, 0, 8'h00, 0, 0, 0);
    step("R6", 1, 0, 1, 8'h00, 0, 8'h00, 0, 0, 0);
    step("R8", 0, 0, 0, 8'h00, 1, 8'h22, 1, 0, 0);
    step("R7", 0, 0, 0, 8'h00, 1, 8'h33, 0, 1, 0);
    step("R6", 1, 0, 1, 8'h00, 1, 8'h44, 1, 1, 0);
    step("R8", 1, 0, 1, 8'h00, 0, 8'h00, 0, 0, 0);
    step("R7", 0, 0, 0, 8'h00, 1, 8'h55, 0, 0, 0);
    step("R7", 0, 0, 0, 8'h00, 1, 8'h66, 0, 0, 0);
    step("R3", 1, 1, 0, 8'hFF, 1, 8'h77, 1, 1, 0);
    step("R3", 1, 1, 0, 8'h14, 0, 8'h00, 0, 0, 0);
    void'($urandom(32'h0000_5eed));
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] r, wd;
      logic sel, wr;
      r = 8'($urandom);
      wd = 8'($urandom);
      sel = r[0];
      wr = (r[3:1] == 3'd0);
      if (wr && sel && wd[1:0] == 2'b11 && r[7:6] != 2'b00) wd[1:0] = 2'b01;
      if (r[5:4] == 2'b00) cts_n = $urandom_range(0, 1) == 0;
      if (r[7:5] == 3'b111) dcd_n = ~dcd_n;
      step("R1", sel, wr, $urandom_range(0, 3) == 0, wd, $urandom_range(0, 2) == 0,
           8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule